// File: doc/BRIEF.md
# I2C Address-Match Wakeup Controller

This block is the control side of an I2C slave that can bring a sleeping system back when a transfer is aimed at it. It keeps a small control register (a wakeup-enable bit, three setup bits and two read-only bus-level bits) and a status word with one sticky error flag. It watches strobes from the bus receiver: start and stop conditions, address match and extension-code reception. The shifter, address comparator, clock generation and glitch filtering lie outside the block and appear here only as these strobes and level inputs.

While wakeup is enabled and the system has entered its stop state, an address match or an extension code produces a one-cycle wake pulse. The stop-condition interrupt is masked for as long as wakeup is enabled. After wakeup is enabled, entry into the stop state is held back for a guard of three clocks. If software drops wakeup enable before any match or extension code arrived, master start requests are refused until the bus shows a new start or stop condition. A refused request sets a sticky error flag.

Top module: `i2c_wake_ctl`

## Requirements
- R1: After reset, with both bus-level inputs low, the control word reads 0x00. The status word reads 0x00, and stop_active, wake, irq and mst_go are all 0.
- R2: The control word (cfg_sel=0) reads wakeup enable at bit 7, the live scl_in at bit 5, the live sda_in at bit 4, mode at bit 3, filter enable at bit 2 and prescaler at bit 0. Bits 6 and 1 always read 0, and writes to bits 6, 5, 4 and 1 have no effect.
- R3: A control write updates bits 3, 2 and 0 only while mod_en is 0. While mod_en is 1 those bits keep their value.
- R4: A write of 1 to bit 7 sets wakeup enable only when st_master, st_ext, st_addr and st_start are all 0. Otherwise the write is ignored. A write of 0 to bit 7 always clears it.
- R5: When wakeup enable is 1, stop_active is 1 and ev_addr or ev_ext is high at a clock edge, wake is 1 for exactly the following cycle and stop_active returns to 0 at that same edge.
- R6: ev_stop with stop_ie high raises irq one edge later only while wakeup enable is 0. While wakeup enable is 1 it has no effect on irq.
- R7: ev_addr or ev_ext raises irq at the next edge whatever the wakeup-enable value. irq stays high until an edge with irq_ack high and no new interrupt event.
- R8: Clearing wakeup enable without an ev_addr or ev_ext having occurred since it was set locks master start. While locked, mst_req gives no mst_go pulse and sets the error flag. An ev_start or ev_stop releases the lock. When not locked, mst_req gives mst_go one cycle later.
- R9: The status word (cfg_sel=1) holds the error flag at bit 0, with all other bits 0. Writing 1 to bit 0 clears the flag.
- R10: A stop_req that finds no guard pending sets stop_active at the next edge. If wakeup enable was set at edge T, stop_active cannot rise before edge T+4. A request made during the guard is held and served when the guard ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_en | input | 1 | Interface operating; locks setup bits |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects control word, 1 selects status word |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected word |
| scl_in | input | 1 | Clock line level |
| sda_in | input | 1 | Data line level |
| st_master | input | 1 | Receiver status: acting as master |
| st_ext | input | 1 | Receiver status: extension code held |
| st_addr | input | 1 | Receiver status: address matched |
| st_start | input | 1 | Receiver status: start detected |
| ev_start | input | 1 | Start condition strobe |
| ev_stop | input | 1 | Stop condition strobe |
| ev_addr | input | 1 | Address match strobe |
| ev_ext | input | 1 | Extension code strobe |
| stop_ie | input | 1 | Stop-condition interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge |
| stop_req | input | 1 | System request to enter the stop state |
| stop_active | output | 1 | System stop state granted |
| wake | output | 1 | One-cycle wake request |
| irq | output | 1 | Held interrupt |
| mst_req | input | 1 | Master start request |
| mst_go | output | 1 | Granted master start pulse |
| mode_sel | output | 1 | Mode bit |
| flt_en | output | 1 | Filter enable bit |
| prs_sel | output | 1 | Prescaler bit |

## Verification
A wrong wakeup-enable bit shows up on the next read of bit 7. It also shows one edge later as a stop interrupt that should have been masked, or as a missing wake pulse. A bad lock or match-seen bit only appears when the next master request arrives: a missing mst_go pulse, or an error flag read from the status word. A guard counter that runs short or long moves the rise of stop_active by whole cycles after the wakeup write, so it is caught by counting edges from that write to the stop grant.

// File: rtl/i2c_wake_ctl.sv
module i2c_wake_ctl #(
  parameter int GUARD = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mod_en,
  input  logic       cfg_we,
  input  logic       cfg_sel,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       st_master,
  input  logic       st_ext,
  input  logic       st_addr,
  input  logic       st_start,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_addr,
  input  logic       ev_ext,
  input  logic       stop_ie,
  input  logic       irq_ack,
  input  logic       stop_req,
  output logic       stop_active,
  output logic       wake,
  output logic       irq,
  input  logic       mst_req,
  output logic       mst_go,
  output logic       mode_sel,
  output logic       flt_en,
  output logic       prs_sel
);
  localparam int GW = $clog2(GUARD + 1);

  logic          wup, seen, lock, pend, err;
  logic [GW-1:0] guard;

  wire wr_ctl   = cfg_we && !cfg_sel;
  wire wr_sts   = cfg_we && cfg_sel;
  wire idle     = !(st_master || st_ext || st_addr || st_start);
  wire hit      = ev_addr || ev_ext;
  wire wup_set  = wr_ctl && cfg_wdata[7] && !wup && idle;
  wire wup_clr  = wr_ctl && !cfg_wdata[7] && wup;
  wire wake_now = wup && stop_active && hit;
  wire guard_ok = (guard == '0) && !wup_set;
  wire irq_set  = hit || (ev_stop && stop_ie && !wup);

  assign cfg_rdata = cfg_sel ? {7'b0, err}
                             : {wup, 1'b0, scl_in, sda_in, mode_sel, flt_en, 1'b0, prs_sel};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {mode_sel, flt_en, prs_sel} <= '0;
    end else if (wr_ctl && !mod_en) begin
      mode_sel <= cfg_wdata[3];
      flt_en   <= cfg_wdata[2];
      prs_sel  <= cfg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wup   <= 1'b0;
      seen  <= 1'b0;
      lock  <= 1'b0;
      guard <= '0;
    end else begin
      if (wup && hit) seen <= 1'b1;
      if (ev_start || ev_stop) lock <= 1'b0;
      if (guard != '0) guard <= guard - 1'b1;
      if (wup_set) begin
        wup   <= 1'b1;
        seen  <= 1'b0;
        guard <= GW'(GUARD);
      end
      if (wup_clr) begin
        wup  <= 1'b0;
        seen <= 1'b0;
        if (!seen && !hit) lock <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_active <= 1'b0;
      pend        <= 1'b0;
      wake        <= 1'b0;
    end else begin
      wake <= wake_now;
      if (stop_active) begin
        if (wake_now) stop_active <= 1'b0;
      end else if ((stop_req || pend) && guard_ok) begin
        stop_active <= 1'b1;
        pend        <= 1'b0;
      end else if (stop_req) begin
        pend <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq    <= 1'b0;
      mst_go <= 1'b0;
      err    <= 1'b0;
    end else begin
      if (irq_set) irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
      mst_go <= mst_req && !lock;
      if (mst_req && lock) err <= 1'b1;
      else if (wr_sts && cfg_wdata[0]) err <= 1'b0;
    end
  end

  p_setup_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mod_en |=> $stable({mode_sel, flt_en, prs_sel}));

  p_wup_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wup) |-> $past(idle && wr_ctl && cfg_wdata[7]));

  p_wake_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  p_wake_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> !stop_active && $past(ev_addr || ev_ext));

  p_stop_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_addr || ev_ext || (ev_stop && stop_ie && !wup)));

  p_go_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mst_go |-> $past(mst_req && !lock));

  p_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_active) |-> !$past(wup_set, 1) && !$past(wup_set, 2) && !$past(wup_set, 3));
endmodule

// File: tb/sim_i2c_wake_ctl.sv
module sim_i2c_wake_ctl;
  logic clk = 0, rst_n = 0;
  logic mod_en = 0, cfg_we = 0, cfg_sel = 0;
  logic [7:0] cfg_wdata = 0;
  logic scl_in = 0, sda_in = 0, st_master = 0, st_ext = 0, st_addr = 0, st_start = 0;
  logic ev_start = 0, ev_stop = 0, ev_addr = 0, ev_ext = 0, stop_ie = 0, irq_ack = 0;
  logic stop_req = 0, mst_req = 0;
  logic [7:0] cfg_rdata;
  logic stop_active, wake, irq, mst_go, mode_sel, flt_en, prs_sel;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_wake_ctl u0 (.*);

  logic m_wup, m_seen, m_lock, m_pend, m_stop, m_wake, m_irq, m_go, m_err, m_mode, m_flt, m_prs;
  int   m_guard;

  always @(posedge clk) begin
    logic hit, idle, set_w, clr_w, wn;
    if (!rst_n) begin
      {m_wup, m_seen, m_lock, m_pend, m_stop, m_wake, m_irq, m_go, m_err, m_mode, m_flt, m_prs} = '0;
      m_guard = 0;
    end else begin
      hit   = ev_addr | ev_ext;
      idle  = !(st_master | st_ext | st_addr | st_start);
      set_w = cfg_we && !cfg_sel && cfg_wdata[7] && !m_wup && idle;
      clr_w = cfg_we && !cfg_sel && !cfg_wdata[7] && m_wup;
      wn    = m_wup && m_stop && hit;
      m_irq = (hit || (ev_stop && stop_ie && !m_wup)) ? 1'b1 : (irq_ack ? 1'b0 : m_irq);
      m_go  = mst_req && !m_lock;
      if (mst_req && m_lock) m_err = 1;
      else if (cfg_we && cfg_sel && cfg_wdata[0]) m_err = 0;
      m_wake = wn;
      if (m_stop) begin
        if (wn) m_stop = 0;
      end else if ((stop_req || m_pend) && m_guard == 0 && !set_w) begin
        m_stop = 1; m_pend = 0;
      end else if (stop_req) m_pend = 1;
      if (cfg_we && !cfg_sel && !mod_en) begin
        m_mode = cfg_wdata[3]; m_flt = cfg_wdata[2]; m_prs = cfg_wdata[0];
      end
      if (m_wup && hit) m_seen = 1;
      if (ev_start || ev_stop) m_lock = 0;
      if (m_guard != 0) m_guard--;
      if (set_w) begin m_wup = 1; m_seen = 0; m_guard = 3; end
      if (clr_w) begin
        if (!m_seen && !hit) m_lock = 1;
        m_wup = 0; m_seen = 0;
      end
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd();
    return cfg_sel ? {7'b0, m_err}
                   : {m_wup, 1'b0, scl_in, sda_in, m_mode, m_flt, 1'b0, m_prs};
  endfunction

  task automatic tick();
    @(negedge clk);
    chk("R2 read word", cfg_rdata, exp_rd());
    chk("R5 wake", {7'b0, wake}, {7'b0, m_wake});
    chk("R10 stop_active", {7'b0, stop_active}, {7'b0, m_stop});
    chk("R6/R7 irq", {7'b0, irq}, {7'b0, m_irq});
    chk("R8 mst_go", {7'b0, mst_go}, {7'b0, m_go});
    chk("R3 setup outputs", {5'b0, mode_sel, flt_en, prs_sel}, {5'b0, m_mode, m_flt, m_prs});
  endtask

  task automatic quiet();
    {cfg_we, cfg_sel, mod_en, st_master, st_ext, st_addr, st_start} = '0;
    {ev_start, ev_stop, ev_addr, ev_ext, stop_ie, irq_ack, stop_req, mst_req} = '0;
    cfg_wdata = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset ctl", cfg_rdata, 8'h00);
    chk("R1 reset outs", {4'b0, stop_active, wake, irq, mst_go}, 8'h00);
    cfg_sel = 1; #1;
    chk("R1 reset status", cfg_rdata, 8'h00);
    cfg_sel = 0;

    // R3: setup bits locked while mod_en=1
    mod_en = 1; cfg_we = 1; cfg_wdata = 8'h0D; tick();
    quiet(); tick();
    chk("R3 locked setup", cfg_rdata & 8'h0D, 8'h00);
    cfg_we = 1; cfg_wdata = 8'h7F; tick();
    quiet(); scl_in = 1; sda_in = 0; tick();
    chk("R2 layout", cfg_rdata, 8'h2D);

    // R4: set refused while a status flag is up
    st_addr = 1; cfg_we = 1; cfg_wdata = 8'h80; tick();
    quiet(); tick();
    chk("R4 gated set", {7'b0, cfg_rdata[7]}, 8'h00);

    // R10: guard after wakeup set, then R5 wake
    cfg_we = 1; cfg_wdata = 8'h80; tick();
    quiet(); stop_req = 1; tick();
    stop_req = 0; tick(); tick();
    chk("R10 held in guard", {7'b0, stop_active}, 8'h00);
    tick();
    chk("R10 granted after guard", {7'b0, stop_active}, 8'h01);
    stop_ie = 1; ev_stop = 1; tick();
    quiet(); tick();
    chk("R6 stop irq masked", {7'b0, irq}, 8'h00);
    ev_addr = 1; tick();
    quiet();
    chk("R5 wake pulse", {6'b0, wake, stop_active}, 8'h02);
    chk("R7 match irq", {7'b0, irq}, 8'h01);
    tick();
    chk("R5 single cycle", {7'b0, wake}, 8'h00);

    // R8: normal clear after match; then abnormal clear
    cfg_we = 1; cfg_wdata = 8'h00; tick();
    quiet(); mst_req = 1; tick();
    mst_req = 0;
    chk("R8 start after normal clear", {7'b0, mst_go}, 8'h01);
    cfg_we = 1; cfg_wdata = 8'h80; tick();
    cfg_wdata = 8'h00; tick();
    quiet(); mst_req = 1; tick();
    mst_req = 0; cfg_sel = 1; tick();
    chk("R8 refused start flags error", {cfg_rdata[0], mst_go}, 8'h02);
    cfg_we = 1; cfg_wdata = 8'h01; tick();
    quiet(); cfg_sel = 1; tick();
    chk("R9 error cleared", cfg_rdata, 8'h00);
    ev_stop = 1; tick();
    quiet(); mst_req = 1; tick();
    mst_req = 0;
    chk("R8 lock released by stop", {7'b0, mst_go}, 8'h01);

    // random phase checked against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      tick();
      mod_en    = ($urandom % 2) == 0;
      cfg_we    = ($urandom % 4) == 0;
      cfg_sel   = ($urandom % 4) == 0;
      cfg_wdata = 8'($urandom);
      scl_in    = 1'($urandom);
      sda_in    = 1'($urandom);
      st_master = ($urandom % 8) == 0;
      st_ext    = ($urandom % 8) == 0;
      st_addr   = ($urandom % 8) == 0;
      st_start  = ($urandom % 8) == 0;
      ev_start  = ($urandom % 10) == 0;
      ev_stop   = ($urandom % 10) == 0;
      ev_addr   = ($urandom % 8) == 0;
      ev_ext    = ($urandom % 12) == 0;
      stop_ie   = 1'($urandom);
      irq_ack   = ($urandom % 4) == 0;
      stop_req  = ($urandom % 6) == 0;
      mst_req   = ($urandom % 8) == 0;
    end
    quiet(); tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule